// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block holds the data-hazard decisions of a five-stage in-order pipeline, and all of its logic is combinational. Each cycle it receives the register-field region of the instruction word from four pipeline registers, together with a small kind code for each: the decode latch (IF/ID), the execute latch (ID/EX), the memory latch (EX/MEM) and the write-back latch (MEM/WB). From these it finds which older instruction writes a register that a younger one reads. It then drives 2-bit select codes for the datapath multiplexers that feed the two ALU operands, the zero test of a conditional branch, and the write-data input of data memory.

Forwarding cannot cover one case: a load followed directly by an instruction that needs the loaded value in execute. The block raises a stall request for that case. The pipeline control then holds the decode latch for one cycle and inserts a bubble into execute. A store that needs a just-loaded value only as its store data does not stall. That value reaches the memory write-data input one stage later, straight from the write-back latch.

Writes happen only in the last stage and reads only in decode, so only read-after-write dependences exist. The block has no streaming interface. All pins are plain control: the kind codes and register fields come in, and the select codes and the stall request go out in the same cycle.

Top module: `fwd_hazard_unit`

## Requirements
- R1: A select code is 00 for the register file, 01 for the EX/MEM ALU result, 10 for the MEM/WB ALU result and 11 for MEM/WB load data. An ALU operand gets 01 when the EX/MEM instruction is register-register (kind 1) or register-immediate (kind 2) and its destination equals the operand's source register.
- R2: Otherwise, an ALU operand whose source register is written by the MEM/WB instruction gets 10 when that instruction is kind 1 or 2, and 11 when it is a load (kind 3).
- R3: When both EX/MEM and MEM/WB write the source register, the EX/MEM (younger) producer decides the code.
- R4: Register 0 is never forwarded and never causes a stall. A source or destination equal to 0 yields code 00 and no stall request.
- R5: When the matching EX/MEM producer is a load, the operand code is 00. The stale MEM/WB value is never chosen in its place.
- R6: Kind codes are 0 none, 1 register-register, 2 register-immediate, 3 load, 4 store and 5 branch. Codes 6 and 7 behave as none. Operand A is used by kinds 1 to 4. Operand B is used by kind 1 and by kind 4 (as store data). A branch uses only the zero-test operand. Any select whose operand is unused is 00.
- R7: When EX/MEM holds a store and MEM/WB writes the store's data register, the store-data select is 10 if MEM/WB is kind 1 or 2 and 11 if it is a load. In every other case the store-data select is 00.
- R8: The branch zero-test select follows the rules of R1 to R5, applied to source field 1 of a branch (kind 5) held in ID/EX.
- R9: The stall request is 1 only when ID/EX holds a load with a nonzero destination that equals a register the IF/ID instruction reads in execute. That means its source field 1 for kinds 1 to 5, or its source field 2 for kind 1.
- R10: A store in IF/ID whose data register (source field 2) matches the load's destination does not stall, unless its base register (source field 1) also matches.
- R11: The port regs field is bits 14..10 source 1, bits 9..5 source 2, bits 4..0 third field. The destination is the third field for kind 1 and the source-2 field for kinds 2 and 3.
- R12: Kinds 0, 4, 5, 6 and 7 write no register and are never a forwarding source or a stall cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_kind | input | 3 | Kind code of the instruction in the decode latch |
| ifid_regs | input | 15 | Register-field region of the decode-latch instruction |
| idex_kind | input | 3 | Kind code of the instruction in the execute latch |
| idex_regs | input | 15 | Register-field region of the execute-latch instruction |
| exmem_kind | input | 3 | Kind code of the instruction in the memory latch |
| exmem_regs | input | 15 | Register-field region of the memory-latch instruction |
| memwb_kind | input | 3 | Kind code of the instruction in the write-back latch |
| memwb_regs | input | 15 | Register-field region of the write-back-latch instruction |
| sel_alu_a | output | 2 | Source select for ALU operand A |
| sel_alu_b | output | 2 | Source select for ALU operand B / store data entering EX/MEM |
| sel_zero_test | output | 2 | Source select for the branch zero-test operand |
| sel_store_data | output | 2 | Source select for the data-memory write-data input |
| stall_req | output | 1 | Hold decode and insert one bubble into execute |

## Verification
The checks assume that the pipeline honours every stall request. As a result, an instruction that reads in execute never sits directly behind a matching load. They also assume that kind codes 6 and 7 appear only as inert filler. The assertions tie each nonzero select to the kind of instruction in the latch it names, and tie the stall request to a load in execute. These relations hold for any combination of inputs, so the sweep drives every kind in every latch with registers 0, 1 and 2. It places a decoy register 3 in the fields that must be ignored. The sweep includes combinations that a stalling pipeline would never present, and R5 defines the code for those.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;

  parameter int unsigned REG_W    = 5;
  parameter int unsigned KIND_W   = 3;
  parameter int unsigned SEL_W    = 2;
  parameter int unsigned NFIELDS  = 3;

  localparam int unsigned REGS_W  = NFIELDS * REG_W;
  localparam int unsigned SRC1_LO = 2 * REG_W;
  localparam int unsigned SRC2_LO = REG_W;
  localparam int unsigned THRD_LO = 0;

  localparam logic [KIND_W-1:0] K_NONE   = 3'd0;
  localparam logic [KIND_W-1:0] K_RR     = 3'd1;
  localparam logic [KIND_W-1:0] K_RI     = 3'd2;
  localparam logic [KIND_W-1:0] K_LOAD   = 3'd3;
  localparam logic [KIND_W-1:0] K_STORE  = 3'd4;
  localparam logic [KIND_W-1:0] K_BRANCH = 3'd5;

  localparam logic [SEL_W-1:0] SEL_RF      = 2'b00;
  localparam logic [SEL_W-1:0] SEL_EXM_ALU = 2'b01;
  localparam logic [SEL_W-1:0] SEL_MWB_ALU = 2'b10;
  localparam logic [SEL_W-1:0] SEL_MWB_LD  = 2'b11;

  // Decoded view of one pipeline latch.
  typedef struct packed {
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic [REG_W-1:0] dst;
    logic             wr;      // writes a nonzero register
    logic             ld;      // producer is a load
    logic             use_a;   // reads src1 as ALU operand A
    logic             use_b;   // reads src2 on the operand-B path
    logic             use_z;   // reads src1 as zero-test operand
    logic             st;      // store: src2 is data, not ALU input
  } stage_t;

endpackage

// File: rtl/fwdu_decode.sv
module fwdu_decode
  import fwdu_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic [REGS_W-1:0] regs,
  output stage_t            info
);

  logic [REG_W-1:0] f_src1;
  logic [REG_W-1:0] f_src2;
  logic [REG_W-1:0] f_thrd;
  logic             is_writer;

  assign f_src1 = regs[SRC1_LO +: REG_W];
  assign f_src2 = regs[SRC2_LO +: REG_W];
  assign f_thrd = regs[THRD_LO +: REG_W];

  always_comb begin
    info       = '0;
    info.src1  = f_src1;
    info.src2  = f_src2;
    is_writer  = 1'b0;
    unique case (kind)
      K_RR: begin
        info.dst   = f_thrd;
        is_writer  = 1'b1;
        info.use_a = 1'b1;
        info.use_b = 1'b1;
      end
      K_RI: begin
        info.dst   = f_src2;
        is_writer  = 1'b1;
        info.use_a = 1'b1;
      end
      K_LOAD: begin
        info.dst   = f_src2;
        is_writer  = 1'b1;
        info.ld    = 1'b1;
        info.use_a = 1'b1;
      end
      K_STORE: begin
        info.use_a = 1'b1;
        info.use_b = 1'b1;
        info.st    = 1'b1;
      end
      K_BRANCH: begin
        info.use_z = 1'b1;
      end
      default: begin
        info.dst = '0;
      end
    endcase
    info.wr = is_writer && (info.dst != '0);
  end

endmodule

// File: rtl/fwdu_pick.sv
module fwdu_pick
  import fwdu_pkg::*;
#(
  parameter bit USE_EXMEM = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  stage_t           exm,
  input  stage_t           mwb,
  output logic [SEL_W-1:0] sel
);

  logic exm_hit;
  logic mwb_hit;
  logic live;

  assign live    = used && (src != '0);
  assign mwb_hit = live && mwb.wr && (mwb.dst == src);

  generate
    if (USE_EXMEM) begin : g_exm
      assign exm_hit = live && exm.wr && (exm.dst == src);
    end else begin : g_no_exm
      assign exm_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    sel = SEL_RF;
    if (exm_hit) begin
      sel = exm.ld ? SEL_RF : SEL_EXM_ALU;
    end else if (mwb_hit) begin
      sel = mwb.ld ? SEL_MWB_LD : SEL_MWB_ALU;
    end
  end

endmodule

// File: rtl/fwdu_interlock.sv
module fwdu_interlock
  import fwdu_pkg::*;
(
  input  logic [REG_W-1:0] rd_src1,
  input  logic [REG_W-1:0] rd_src2,
  input  logic             rd_use1,
  input  logic             rd_use2_ex,
  input  logic [REG_W-1:0] ld_dst,
  input  logic             ld_live,
  output logic             stall
);

  logic hit1;
  logic hit2;

  assign hit1  = rd_use1    && (rd_src1 == ld_dst);
  assign hit2  = rd_use2_ex && (rd_src2 == ld_dst);
  assign stall = ld_live && (hit1 || hit2);

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwdu_pkg::*;
(
  input  logic [KIND_W-1:0] ifid_kind,
  input  logic [REGS_W-1:0] ifid_regs,
  input  logic [KIND_W-1:0] idex_kind,
  input  logic [REGS_W-1:0] idex_regs,
  input  logic [KIND_W-1:0] exmem_kind,
  input  logic [REGS_W-1:0] exmem_regs,
  input  logic [KIND_W-1:0] memwb_kind,
  input  logic [REGS_W-1:0] memwb_regs,
  output logic [SEL_W-1:0]  sel_alu_a,
  output logic [SEL_W-1:0]  sel_alu_b,
  output logic [SEL_W-1:0]  sel_zero_test,
  output logic [SEL_W-1:0]  sel_store_data,
  output logic              stall_req
);

  localparam int unsigned NSTAGE = 4;
  localparam int unsigned S_IFID = 0;
  localparam int unsigned S_IDEX = 1;
  localparam int unsigned S_EXM  = 2;
  localparam int unsigned S_MWB  = 3;

  logic [KIND_W-1:0] kinds [NSTAGE];
  logic [REGS_W-1:0] regss [NSTAGE];
  stage_t            st    [NSTAGE];

  assign kinds[S_IFID] = ifid_kind;
  assign kinds[S_IDEX] = idex_kind;
  assign kinds[S_EXM]  = exmem_kind;
  assign kinds[S_MWB]  = memwb_kind;
  assign regss[S_IFID] = ifid_regs;
  assign regss[S_IDEX] = idex_regs;
  assign regss[S_EXM]  = exmem_regs;
  assign regss[S_MWB]  = memwb_regs;

  generate
    for (genvar g = 0; g < NSTAGE; g++) begin : g_dec
      fwdu_decode u_dec (
        .kind (kinds[g]),
        .regs (regss[g]),
        .info (st[g])
      );
    end
  endgenerate

  fwdu_pick #(.USE_EXMEM(1'b1)) u_pick_a (
    .src  (st[S_IDEX].src1),
    .used (st[S_IDEX].use_a),
    .exm  (st[S_EXM]),
    .mwb  (st[S_MWB]),
    .sel  (sel_alu_a)
  );

  fwdu_pick #(.USE_EXMEM(1'b1)) u_pick_b (
    .src  (st[S_IDEX].src2),
    .used (st[S_IDEX].use_b),
    .exm  (st[S_EXM]),
    .mwb  (st[S_MWB]),
    .sel  (sel_alu_b)
  );

  fwdu_pick #(.USE_EXMEM(1'b1)) u_pick_z (
    .src  (st[S_IDEX].src1),
    .used (st[S_IDEX].use_z),
    .exm  (st[S_EXM]),
    .mwb  (st[S_MWB]),
    .sel  (sel_zero_test)
  );

  // Store data at the memory stage: only the write-back latch is older.
  fwdu_pick #(.USE_EXMEM(1'b0)) u_pick_m (
    .src  (st[S_EXM].src2),
    .used (st[S_EXM].st),
    .exm  (st[S_EXM]),
    .mwb  (st[S_MWB]),
    .sel  (sel_store_data)
  );

  fwdu_interlock u_lock (
    .rd_src1    (st[S_IFID].src1),
    .rd_src2    (st[S_IFID].src2),
    .rd_use1    (st[S_IFID].use_a || st[S_IFID].use_z),
    .rd_use2_ex (st[S_IFID].use_b && !st[S_IFID].st),
    .ld_dst     (st[S_IDEX].dst),
    .ld_live    (st[S_IDEX].ld && st[S_IDEX].wr),
    .stall      (stall_req)
  );

endmodule

// File: rtl/fwdu_chk.sv
module fwdu_chk
  import fwdu_pkg::*;
(
  input logic [KIND_W-1:0] ifid_kind,
  input logic [REGS_W-1:0] ifid_regs,
  input logic [KIND_W-1:0] idex_kind,
  input logic [REGS_W-1:0] idex_regs,
  input logic [KIND_W-1:0] exmem_kind,
  input logic [REGS_W-1:0] exmem_regs,
  input logic [KIND_W-1:0] memwb_kind,
  input logic [REGS_W-1:0] memwb_regs,
  input logic [SEL_W-1:0]  sel_alu_a,
  input logic [SEL_W-1:0]  sel_alu_b,
  input logic [SEL_W-1:0]  sel_zero_test,
  input logic [SEL_W-1:0]  sel_store_data,
  input logic              stall_req
);

  logic known;
  logic exm_alu;
  logic mwb_alu;
  logic any01;
  logic any10;
  logic any11;

  assign known   = !$isunknown({ifid_kind, ifid_regs, idex_kind, idex_regs,
                                exmem_kind, exmem_regs, memwb_kind, memwb_regs,
                                sel_alu_a, sel_alu_b, sel_zero_test,
                                sel_store_data, stall_req});
  assign exm_alu = (exmem_kind == K_RR) || (exmem_kind == K_RI);
  assign mwb_alu = (memwb_kind == K_RR) || (memwb_kind == K_RI);
  assign any01   = (sel_alu_a == SEL_EXM_ALU) || (sel_alu_b == SEL_EXM_ALU) ||
                   (sel_zero_test == SEL_EXM_ALU) || (sel_store_data == SEL_EXM_ALU);
  assign any10   = (sel_alu_a == SEL_MWB_ALU) || (sel_alu_b == SEL_MWB_ALU) ||
                   (sel_zero_test == SEL_MWB_ALU) || (sel_store_data == SEL_MWB_ALU);
  assign any11   = (sel_alu_a == SEL_MWB_LD) || (sel_alu_b == SEL_MWB_LD) ||
                   (sel_zero_test == SEL_MWB_LD) || (sel_store_data == SEL_MWB_LD);

  always_comb begin
    if (known) begin
      // R9
      stall_from_load_chk: assert (!stall_req ||
        ((idex_kind == K_LOAD) && (idex_regs[SRC2_LO +: REG_W] != '0)));
      // R7
      store_sel_kind_chk: assert ((sel_store_data == SEL_RF) || (exmem_kind == K_STORE));
      // R8
      zero_sel_kind_chk: assert ((sel_zero_test == SEL_RF) || (idex_kind == K_BRANCH));
      // R1
      exm_src_alu_chk: assert (!any01 || exm_alu);
      // R2
      mwb_ld_src_chk: assert (!any11 || (memwb_kind == K_LOAD));
      // R12
      mwb_alu_src_chk: assert (!any10 || mwb_alu);
      // R4
      zero_reg_quiet_chk: assert ((idex_regs[SRC1_LO +: REG_W] != '0) ||
        ((sel_alu_a == SEL_RF) && (sel_zero_test == SEL_RF)));
    end
  end

endmodule

bind fwd_hazard_unit fwdu_chk u_chk (.*);

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;

  logic       clk = 1'b0;
  logic [2:0] ifid_kind, idex_kind, exmem_kind, memwb_kind;
  logic [14:0] ifid_regs, idex_regs, exmem_regs, memwb_regs;
  logic [1:0] sel_alu_a, sel_alu_b, sel_zero_test, sel_store_data;
  logic       stall_req;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fwd_hazard_unit u_dut (
    .ifid_kind(ifid_kind), .ifid_regs(ifid_regs),
    .idex_kind(idex_kind), .idex_regs(idex_regs),
    .exmem_kind(exmem_kind), .exmem_regs(exmem_regs),
    .memwb_kind(memwb_kind), .memwb_regs(memwb_regs),
    .sel_alu_a(sel_alu_a), .sel_alu_b(sel_alu_b),
    .sel_zero_test(sel_zero_test), .sel_store_data(sel_store_data),
    .stall_req(stall_req)
  );

  function automatic bit writes(int k);
    return (k == 1) || (k == 2) || (k == 3);
  endfunction

  function automatic int dest(int k, logic [14:0] r);
    return (k == 1) ? int'(r[4:0]) : int'(r[9:5]);
  endfunction

  // Expected code from the requirement text (R1..R5, R12).
  function automatic int expect_sel(int src, bit used, bit with_exm,
                                    int ek, logic [14:0] er,
                                    int mk, logic [14:0] mr);
    if (!used || src == 0) return 0;
    if (with_exm && writes(ek) && dest(ek, er) == src)
      return (ek == 3) ? 0 : 1;
    if (writes(mk) && dest(mk, mr) == src)
      return (mk == 3) ? 3 : 2;
    return 0;
  endfunction

  function automatic logic [14:0] producer(int k, int d);
    logic [4:0] dd;
    dd = 5'(d);
    if (k == 1) return {5'd3, 5'd3, dd};
    return {5'd3, dd, 5'd3};
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (ifid %0d/%h idex %0d/%h exm %0d/%h mwb %0d/%h)",
               req, act, exp, ifid_kind, ifid_regs, idex_kind, idex_regs,
               exmem_kind, exmem_regs, memwb_kind, memwb_regs);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    ifid_kind = '0; idex_kind = '0; exmem_kind = '0; memwb_kind = '0;
    ifid_regs = '0; idex_regs = '0; exmem_regs = '0; memwb_regs = '0;
    @(negedge clk);
    // Idle pipeline: every select at register file, no stall (R1, R9).
    check("R1 idle a", int'(sel_alu_a), 0);
    check("R1 idle b", int'(sel_alu_b), 0);
    check("R8 idle z", int'(sel_zero_test), 0);
    check("R7 idle m", int'(sel_store_data), 0);
    check("R9 idle stall", int'(stall_req), 0);

    // Directed: load then store of the loaded register, store data via load path (R7, R10).
    @(posedge clk);
    ifid_kind = 3'd4; ifid_regs = {5'd2, 5'd1, 5'd3};   // store base r2, data r1
    idex_kind = 3'd3; idex_regs = {5'd2, 5'd1, 5'd3};   // load to r1
    @(negedge clk);
    check("R10 store data no stall", int'(stall_req), 0);
    @(posedge clk);
    ifid_regs = {5'd1, 5'd1, 5'd3};
    @(negedge clk);
    check("R10 store base stalls", int'(stall_req), 1);

    // Full sweep of the forwarding selects (R1-R8, R11, R12).
    for (int ik = 0; ik < 8; ik++)
      for (int ek = 0; ek < 8; ek++)
        for (int mk = 0; mk < 8; mk++)
          for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
              for (int ed = 0; ed < 3; ed++)
                for (int md = 0; md < 3; md++) begin
                  @(posedge clk);
                  ifid_kind  = 3'd0; ifid_regs = '0;
                  idex_kind  = 3'(ik); idex_regs  = {5'(a), 5'(b), 5'd3};
                  exmem_kind = 3'(ek); exmem_regs = producer(ek, ed);
                  memwb_kind = 3'(mk); memwb_regs = producer(mk, md);
                  @(negedge clk);
                  begin
                    bit ua, ub, uz, um;
                    ua = (ik >= 1) && (ik <= 4);
                    ub = (ik == 1) || (ik == 4);
                    uz = (ik == 5);
                    um = (ek == 4);
                    check("R1 R2 R3 R5 R6 alu_a", int'(sel_alu_a),
                          expect_sel(a, ua, 1'b1, ek, exmem_regs, mk, memwb_regs));
                    check("R1 R2 R3 R5 R6 alu_b", int'(sel_alu_b),
                          expect_sel(b, ub, 1'b1, ek, exmem_regs, mk, memwb_regs));
                    check("R8 zero_test", int'(sel_zero_test),
                          expect_sel(a, uz, 1'b1, ek, exmem_regs, mk, memwb_regs));
                    check("R7 store_data", int'(sel_store_data),
                          expect_sel(ed, um, 1'b0, ek, exmem_regs, mk, memwb_regs));
                    check("R9 no stall when decode empty", int'(stall_req), 0);
                  end
                end

    // Stall sweep (R4, R9, R10, R11, R12).
    for (int fk = 0; fk < 8; fk++)
      for (int ik = 0; ik < 8; ik++)
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            for (int d = 0; d < 3; d++) begin
              @(posedge clk);
              ifid_kind  = 3'(fk); ifid_regs = {5'(a), 5'(b), 5'd3};
              idex_kind  = 3'(ik); idex_regs = producer(ik, d);
              exmem_kind = 3'd0; exmem_regs = '0;
              memwb_kind = 3'd0; memwb_regs = '0;
              @(negedge clk);
              begin
                bit r1, r2, exp_st;
                r1 = (fk >= 1) && (fk <= 5) && (a == d);
                r2 = (fk == 1) && (b == d);
                exp_st = (ik == 3) && (d != 0) && (r1 || r2);
                check("R9 R10 stall", int'(stall_req), int'(exp_st));
              end
            end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule